// File: doc/BRIEF.md
# Bus-Mastering Block Copy Engine

This block copies a run of words from one region of a shared synchronous memory bus to another, so that the processor does not have to move them itself. Software loads a source address, a destination address and a word count through a small four-entry register port. It then writes a start command to the control word. The engine asks an external arbiter for the bus and waits for the grant. It then copies each word by reading the source location and writing the data it got back to the destination location. Each word advances both addresses by one and lowers the count by one.

Two pacing modes are offered. In continuous mode the engine keeps its bus request raised until the last word is written. In cycle-stealing mode it gives the bus back after every word and stays off it for a programmable number of cycles. It then asks again, which leaves regular slots for the processor. At the end of the run a done flag is raised in status and an interrupt line is driven. Both stay up until software clears them.

Top module: `dma_engine`

## Requirements
- R1: After a synchronous reset, bus_req, mem_en and irq are low, and all four registers read as zero.
- R2: Register offsets are 0 = source address, 1 = destination address, 2 = word count and 3 = control/status. A control write uses bit 0 for start, bit 1 to select cycle-stealing, bit 2 to clear done, and bits 15:8 for the idle gap. A status read gives bit 0 busy, bit 1 stealing, bit 2 done and bits 15:8 the gap. cfg_rdata shows the register selected by cfg_addr one clock later.
- R3: The clock edge that accepts a start raises bus_req. No memory cycle is driven until bus_gnt has been sampled high.
- R4: Each word is copied as a read of the source address, followed by a write to the destination address of the data that read returned. After each write, the source and destination addresses go up by one and the count goes down by one.
- R5: In continuous mode, with the grant held, bus_req stays high for the whole run and a new word starts every 3 cycles. An N-word run therefore sets irq 3N+1 clocks after the start edge.
- R6: In cycle-stealing mode, after every word except the last, bus_req goes low for exactly G cycles, where G is the gap field (a gap of 0 counts as 1). The engine then requests the bus again. An N-word run sets irq 4+(N-1)(G+4) clocks after the start edge.
- R7: On the write of the final word, bus_req drops and the done flag and irq are set. They stay set until a control write, made while idle, with the clear bit or the start bit set.
- R8: A start with a word count of zero never raises bus_req. It sets done and irq on the start edge.
- R9: While busy, writes to any register are ignored: the run keeps its addresses, count, mode and gap.
- R10: If bus_gnt falls during a run, the word whose read has already been issued still completes its write. bus_req stays high, and the next read waits until bus_gnt returns. No word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Registered read data |
| irq | output | 1 | Completion interrupt (level) |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership grant |
| mem_en | output | 1 | Memory cycle valid |
| mem_wr | output | 1 | Memory cycle is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read |

## Verification
The copy path is run in continuous mode with the grant held throughout. It is then run in cycle-stealing mode with a gap of three and with a gap of zero, which separates the pacing counter's load value from its zero-means-one rule. A continuous run in which the grant is removed partway through shows whether an issued word is completed and whether the engine resumes in the right place. A zero-length start and a run that is held off by a low grant while its registers are rewritten cover the start edge cases and the ignored writes. The exact cycle on which irq rises distinguishes the two pacing modes from each other and from an off-by-one in the gap.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RD, ST_WT, ST_WR, ST_GAP
  } mv_state_t;

  localparam logic [1:0] REG_SRC = 2'd0;
  localparam logic [1:0] REG_DST = 2'd1;
  localparam logic [1:0] REG_CNT = 2'd2;
  localparam logic [1:0] REG_CTL = 2'd3;

  localparam int unsigned CTL_GO      = 0;
  localparam int unsigned CTL_STEAL   = 1;
  localparam int unsigned CTL_CLR     = 2;
  localparam int unsigned CTL_GAP_LSB = 8;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          busy,
  input  logic          step,
  input  logic          fin,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic          steal_o,
  output logic [PW-1:0] gap_o,
  output logic          go_o,
  output logic          irq_o
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          steal_q, done_q;
  logic [PW-1:0] gap_q;
  logic          wr_ok, ctl_wr, clr_req;
  logic [DW-1:0] stat;

  assign wr_ok   = cfg_we && !busy;
  assign ctl_wr  = wr_ok && (cfg_addr == REG_CTL);
  assign go_o    = ctl_wr && cfg_wdata[CTL_GO];
  assign clr_req = ctl_wr && (cfg_wdata[CTL_GO] || cfg_wdata[CTL_CLR]);

  always_comb begin
    stat = '0;
    stat[0] = busy;
    stat[1] = steal_q;
    stat[2] = done_q;
    stat[CTL_GAP_LSB +: PW] = gap_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      steal_q   <= 1'b0;
      gap_q     <= '0;
      done_q    <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      if (step) begin
        src_q <= src_q + 1'b1;
        dst_q <= dst_q + 1'b1;
        cnt_q <= cnt_q - 1'b1;
      end else if (wr_ok) begin
        case (cfg_addr)
          REG_SRC: src_q <= cfg_wdata[AW-1:0];
          REG_DST: dst_q <= cfg_wdata[AW-1:0];
          REG_CNT: cnt_q <= cfg_wdata[CW-1:0];
          default: begin
            steal_q <= cfg_wdata[CTL_STEAL];
            gap_q   <= cfg_wdata[CTL_GAP_LSB +: PW];
          end
        endcase
      end
      if (fin)          done_q <= 1'b1;
      else if (clr_req) done_q <= 1'b0;
      case (cfg_addr)
        REG_SRC: cfg_rdata <= DW'(src_q);
        REG_DST: cfg_rdata <= DW'(dst_q);
        REG_CNT: cfg_rdata <= DW'(cnt_q);
        default: cfg_rdata <= stat;
      endcase
    end
  end

  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign cnt_o   = cnt_q;
  assign steal_o = steal_q;
  assign gap_o   = gap_q;
  assign irq_o   = done_q;

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt_q == $past(cnt_q) - 1'b1) && (src_q == $past(src_q) + 1'b1));

  assert_busy_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !step) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)
                         && $stable(steal_q) && $stable(gap_q)));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (done_q && !clr_req) |=> done_q);
endmodule

// File: rtl/dma_pacer.sv
module dma_pacer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] gap,
  output logic          expire
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= (gap == '0) ? PW'(1) : gap;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == PW'(1));

  assert_gap_loaded_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q != '0));
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [CW-1:0] cnt,
  input  logic          steal,
  input  logic          bus_gnt,
  input  logic [DW-1:0] mem_rdata,
  input  logic          pace_expire,
  output logic          bus_req,
  output logic          mem_en,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          step,
  output logic          fin,
  output logic          pace_load
);
  mv_state_t state;
  logic      last;

  assign last      = (cnt == CW'(1));
  assign busy      = (state != ST_IDLE);
  assign step      = (state == ST_WR);
  assign fin       = ((state == ST_IDLE) && go && (cnt == '0)) || (step && last);
  assign pace_load = step && !last && steal;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_req   <= 1'b0;
      mem_en    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_en <= 1'b0;
      mem_wr <= 1'b0;
      case (state)
        ST_IDLE: if (go && cnt != '0) begin
          state   <= ST_REQ;
          bus_req <= 1'b1;
        end
        ST_REQ: if (bus_gnt) begin
          mem_en   <= 1'b1;
          mem_addr <= src;
          state    <= ST_RD;
        end
        ST_RD: state <= ST_WT;
        ST_WT: begin
          mem_en    <= 1'b1;
          mem_wr    <= 1'b1;
          mem_addr  <= dst;
          mem_wdata <= mem_rdata;
          state     <= ST_WR;
        end
        ST_WR: begin
          if (last) begin
            bus_req <= 1'b0;
            state   <= ST_IDLE;
          end else if (steal) begin
            bus_req <= 1'b0;
            state   <= ST_GAP;
          end else if (bus_gnt) begin
            mem_en   <= 1'b1;
            mem_addr <= src + 1'b1;
            state    <= ST_RD;
          end else begin
            state <= ST_REQ;
          end
        end
        ST_GAP: if (pace_expire) begin
          bus_req <= 1'b1;
          state   <= ST_REQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_read_after_grant_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_wr) |-> $past(bus_gnt));

  assert_bus_owned_R3: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> bus_req);

  assert_zero_len_R8: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && go && (cnt == '0)) |=> (!bus_req && state == ST_IDLE));

  assert_pace_in_gap_R6: assert property (@(posedge clk) disable iff (rst)
    pace_expire |-> (state == ST_GAP));
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_en,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic [PW-1:0] gap;
  logic          steal, go, busy, step, fin, pace_load, pace_expire;

  dma_regs #(.AW(AW), .DW(DW), .CW(CW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .step(step),
    .fin(fin), .src_o(src), .dst_o(dst), .cnt_o(cnt), .steal_o(steal),
    .gap_o(gap), .go_o(go), .irq_o(irq)
  );

  dma_pacer #(.PW(PW)) u_pacer (
    .clk(clk), .rst(rst), .load(pace_load), .gap(gap), .expire(pace_expire)
  );

  dma_mover #(.AW(AW), .DW(DW), .CW(CW)) u_mover (
    .clk(clk), .rst(rst), .go(go), .src(src), .dst(dst), .cnt(cnt),
    .steal(steal), .bus_gnt(bus_gnt), .mem_rdata(mem_rdata),
    .pace_expire(pace_expire), .bus_req(bus_req), .mem_en(mem_en),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .step(step), .fin(fin), .pace_load(pace_load)
  );
endmodule

// File: tb/sim_dma_engine.sv
module sim_dma_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq, bus_req, mem_en, mem_wr;
  logic        bus_gnt = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem [0:255];

  int n_chk = 0, n_fail = 0, cyc = 0;
  int viol_grant = 0, viol_req = 0, n_rd = 0, n_wr = 0;
  int low_run = 0, gap_min = 0, gap_max = 0;
  logic track = 1'b0, seen_hi = 1'b0, gnt_prev = 1'b0;

  always #10 clk = ~clk;

  dma_engine u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    gnt_prev <= bus_gnt;
    if (mem_en && !mem_wr) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_en && mem_wr)  mem[mem_addr[7:0]] <= mem_wdata;
  end

  always @(negedge clk) begin
    cyc++;
    if (mem_en && !mem_wr) begin n_rd++; if (!gnt_prev) viol_grant++; end
    if (mem_en && mem_wr) n_wr++;
    if (mem_en && !bus_req) viol_req++;
    if (track) begin
      if (bus_req) begin
        if (seen_hi && low_run != 0) begin
          if (gap_min == 0 || low_run < gap_min) gap_min = low_run;
          if (low_run > gap_max) gap_max = low_run;
        end
        seen_hi = 1'b1;
        low_run = 0;
      end else low_run++;
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] <= 32'hA500_0000 | i;
    @(negedge clk);
  endtask

  task automatic clear_mon();
    viol_grant = 0; viol_req = 0; n_rd = 0; n_wr = 0;
    low_run = 0; gap_min = 0; gap_max = 0; seen_hi = 1'b0;
  endtask

  task automatic wait_irq(output int waited);
    waited = 0;
    while (!irq && waited < 2000) begin @(negedge clk); waited++; end
  endtask

  task automatic check_copy(input string tag, input int s, input int d, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (mem[d + i] !== (32'hA500_0000 | (s + i))) bad++;
    check({tag, " words copied"}, bad, 0);
    check({tag, " word past end untouched"}, mem[d + n], 32'hA500_0000 | (d + n));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 bus_req", {31'd0, bus_req}, 0);
    check("R1 mem_en", {31'd0, mem_en}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), v);
      check("R1 register zero", v, 0);
    end
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    reg_write(2'd0, 32'h0000_1234); reg_write(2'd1, 32'h0000_0BCD);
    reg_write(2'd2, 32'h0000_0077); reg_write(2'd3, 32'h0000_0502);
    reg_read(2'd0, v); check("R2 source", v, 32'h1234);
    reg_read(2'd1, v); check("R2 destination", v, 32'h0BCD);
    reg_read(2'd2, v); check("R2 count", v, 32'h77);
    reg_read(2'd3, v); check("R2 status gap/steal", v, 32'h0502);
  endtask

  task automatic t_continuous();
    int w;
    logic [31:0] v;
    init_mem(); clear_mon(); bus_gnt = 1'b1;
    reg_write(2'd0, 32'h10); reg_write(2'd1, 32'h80); reg_write(2'd2, 8);
    track = 1'b1;
    reg_write(2'd3, 32'h1);
    check("R3 request on start edge", {31'd0, bus_req}, 1);
    wait_irq(w);
    track = 1'b0;
    check("R5 irq cycle continuous", w, 3 * 8 + 1);
    check("R5 no request drop", gap_max, 0);
    check("R7 request released", {31'd0, bus_req}, 0);
    check_copy("R4 continuous", 16'h10, 16'h80, 8);
    check("R4 read count", n_rd, 8);
    check("R3 reads only under grant", viol_grant, 0);
    reg_read(2'd0, v); check("R4 source advanced", v, 32'h18);
    reg_read(2'd2, v); check("R4 count exhausted", v, 0);
    reg_read(2'd3, v); check("R7 done bit", v & 32'h7, 32'h4);
    repeat (5) @(negedge clk);
    check("R7 irq held", {31'd0, irq}, 1);
    reg_write(2'd3, 32'h4);
    check("R7 irq cleared", {31'd0, irq}, 0);
    reg_read(2'd3, v); check("R7 done cleared", v & 32'h4, 0);
  endtask

  task automatic t_steal(input int g, input int n);
    int w;
    int eg;
    init_mem(); clear_mon(); bus_gnt = 1'b1;
    eg = (g == 0) ? 1 : g;
    reg_write(2'd0, 32'h20); reg_write(2'd1, 32'h90); reg_write(2'd2, n);
    track = 1'b1;
    reg_write(2'd3, (g << 8) | 32'h3);
    wait_irq(w);
    track = 1'b0;
    check("R6 irq cycle stealing", w, 4 + (n - 1) * (eg + 4));
    check("R6 min idle gap", gap_min, eg);
    check("R6 max idle gap", gap_max, eg);
    check_copy("R6 stealing", 16'h20, 16'h90, n);
    check("R3 reads only under grant", viol_grant + viol_req, 0);
    reg_write(2'd3, 32'h4);
  endtask

  task automatic t_zero_len();
    clear_mon(); bus_gnt = 1'b1;
    reg_write(2'd2, 0);
    track = 1'b1;
    reg_write(2'd3, 32'h1);
    check("R8 done on start edge", {31'd0, irq}, 1);
    repeat (6) @(negedge clk);
    track = 1'b0;
    check("R8 no request", {31'd0, seen_hi}, 0);
    check("R8 no memory cycles", n_rd + n_wr, 0);
    reg_write(2'd3, 32'h4);
  endtask

  task automatic t_busy_ignore();
    int w;
    logic [31:0] v;
    init_mem(); clear_mon(); bus_gnt = 1'b0;
    reg_write(2'd0, 32'h30); reg_write(2'd1, 32'hA0); reg_write(2'd2, 6);
    reg_write(2'd3, 32'h1);
    repeat (4) @(negedge clk);
    check("R3 no cycle before grant", n_rd + n_wr, 0);
    reg_write(2'd0, 32'h55); reg_write(2'd1, 32'h66);
    reg_write(2'd2, 32'h3); reg_write(2'd3, 32'h0903);
    reg_read(2'd3, v); check("R9 status busy, mode kept", v, 32'h1);
    bus_gnt = 1'b1;
    wait_irq(w);
    check_copy("R9 busy writes ignored", 16'h30, 16'hA0, 6);
    check("R9 word count kept", n_wr, 6);
    reg_write(2'd3, 32'h4);
  endtask

  task automatic t_grant_drop();
    int w;
    init_mem(); clear_mon(); bus_gnt = 1'b1;
    reg_write(2'd0, 32'h40); reg_write(2'd1, 32'hC0); reg_write(2'd2, 8);
    track = 1'b1;
    reg_write(2'd3, 32'h1);
    repeat (5) @(negedge clk);
    bus_gnt = 1'b0;
    repeat (9) @(negedge clk);
    bus_gnt = 1'b1;
    wait_irq(w);
    track = 1'b0;
    check("R10 request held while waiting", gap_max, 0);
    check("R10 no read without grant", viol_grant, 0);
    check("R10 reads", n_rd, 8);
    check("R10 writes", n_wr, 8);
    check_copy("R10 resumed", 16'h40, 16'hC0, 8);
    reg_write(2'd3, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_continuous();
    t_steal(3, 4);
    t_steal(0, 3);
    t_zero_len();
    t_busy_ignore();
    t_grant_drop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule